// File: doc/BRIEF.md
# Filtered Performance Event Counter

This block is one counting slice of a performance monitor. Every cycle it sees a bank of event sources. Each source offers an increment value for that cycle and a byte of subevent lines. Two 32-bit control words are written through a simple register port. They choose one source, qualify it with a subevent mask, and pick how the count grows. The count can accumulate the raw increment, count only rising edges of the event, count cycles that pass a threshold test whose polarity can be inverted, or track the largest increment seen.

The count lives in a data register of `CNT_W` bits, 48 by default, which wraps modulo 2^CNT_W. A wrap sets a sticky overflow flag. When the freeze enable bit is set, that flag raises a freeze request toward the monitor's global control. An external freeze input stops the count from changing. A write-one clear strobe zeroes the counter and the flag even while the freeze input is held.

Top module: `perf_event_counter`

## Requirements
- R1: Low-word bits 7:0 select the source index that feeds the counter. Any index at or above `NUM_SRC` gives an event that is never active, so the count stays unchanged.
- R2: Low-word bits 15:8 are a subevent mask. When the mask is non-zero, the selected event is active only in cycles where the mask ANDed with that source's subevent lines is non-zero. When the mask is zero, the subevent lines are ignored. In both cases the event is active only when its increment is non-zero.
- R3: A write to the low word with bit 17 set zeroes the counter and the overflow flag at the edge that takes the write. This clear beats counting and beats the freeze input. Bit 17 always reads back as 0.
- R4: With bit 18, the threshold, and max mode all zero, each active cycle adds that cycle's increment. The result is visible on `cnt_value` after that cycle's clock edge.
- R5: With bit 18 set, the increment is added only in a cycle where the event is active and was not active in the cycle before. The event counts as inactive before the first cycle after reset.
- R6: With the threshold in bits 31:24 non-zero and bit 23 zero, the counter adds exactly 1 in each cycle where the candidate increment is >= the threshold, and adds 0 otherwise. A zero threshold turns the filter off.
- R7: With a non-zero threshold and bit 23 set, the counter adds 1 in each cycle where the candidate increment is < the threshold. This includes idle cycles, whose candidate is 0.
- R8: With high-word bit 0 set, the counter loads the candidate increment only when it is strictly greater than the stored value. In this mode the threshold is ignored and the counter never overflows.
- R9: The count wraps modulo 2^CNT_W. A wrap sets `ovf_flag`, which stays set until a clear (R3) or a reset.
- R10: `freeze_req` is high exactly while `ovf_flag` is set and low-word bit 20 is set.
- R11: While `freeze_in` is high, the counter holds its value unless a clear occurs.
- R12: After reset, all control fields, the counter and the flag are zero. `cfg_rdata` shows the low word when `cfg_addr` is 0 and the high word when it is 1. Bits 16, 19, 21 and 22 of the low word and bits 31:1 of the high word read as zero. Writes take effect at the clock edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| cfg_we | input | 1 | Control word write enable |
| cfg_addr | input | 1 | Control word select: 0 low, 1 high (write and read) |
| cfg_wdata | input | 32 | Write data |
| cfg_rdata | output | 32 | Read data of the selected word |
| src_inc | input | NUM_SRC*INC_W | Per-source increment values, source 0 in the low bits |
| src_sub | input | NUM_SRC*8 | Per-source subevent lines, source 0 in the low byte |
| freeze_in | input | 1 | External freeze: hold the count |
| cnt_value | output | CNT_W | Counter data register |
| ovf_flag | output | 1 | Sticky overflow flag |
| freeze_req | output | 1 | Freeze request toward global control |

## Verification
The bench targets the places where the filters meet. A design that takes the edge history from the raw input instead of the masked event would miss the rising edge that follows a masked-off cycle. An inverted threshold that skipped idle cycles would undercount by one per gap. A max mode that still honoured the threshold would report zero. An out-of-range select that wrapped onto a real source would count the distractor traffic. Further directed tests cover two more behaviours. First, the wrap with a reduced counter width, where a design that saturates or drops the flag shows a wrong residue of 6. Second, the clear given while frozen, which a design that gates the clear with the freeze input would leave at its frozen value.

// File: rtl/pec_pkg.sv
package pec_pkg;
  localparam int SEL_W  = 8;
  localparam int MASK_W = 8;
  localparam int THR_W  = 8;

  localparam int B_CLR  = 17;
  localparam int B_EDGE = 18;
  localparam int B_FRZ  = 20;
  localparam int B_INV  = 23;

  typedef struct packed {
    logic [THR_W-1:0]  thr;
    logic              inv;
    logic              frz_en;
    logic              edge_md;
    logic [MASK_W-1:0] mask;
    logic [SEL_W-1:0]  sel;
    logic              max_md;
  } pec_cfg_t;

  function automatic logic [31:0] pack_lo(input pec_cfg_t c);
    logic [31:0] r;
    r         = '0;
    r[7:0]    = c.sel;
    r[15:8]   = c.mask;
    r[B_EDGE] = c.edge_md;
    r[B_FRZ]  = c.frz_en;
    r[B_INV]  = c.inv;
    r[31:24]  = c.thr;
    return r;
  endfunction

  function automatic logic [31:0] pack_hi(input pec_cfg_t c);
    return {31'b0, c.max_md};
  endfunction
endpackage

// File: rtl/pec_cfg_regs.sv
module pec_cfg_regs
  import pec_pkg::*;
(
  input  logic        clk,
  input  logic        rst_n,
  input  logic        we,
  input  logic        addr,
  input  logic [31:0] wdata,
  output pec_cfg_t    cfg,
  output logic        clr_req
);
  logic unused_bits;
  assign unused_bits = ^{wdata[16], wdata[19], wdata[22:21]};

  assign clr_req = we && !addr && wdata[B_CLR];

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      cfg <= '0;
    end else if (we) begin
      if (addr) begin
        cfg.max_md <= wdata[0];
      end else begin
        cfg.sel     <= wdata[7:0];
        cfg.mask    <= wdata[15:8];
        cfg.edge_md <= wdata[B_EDGE];
        cfg.frz_en  <= wdata[B_FRZ];
        cfg.inv     <= wdata[B_INV];
        cfg.thr     <= wdata[31:24];
      end
    end
  end
endmodule

// File: rtl/pec_event_path.sv
module pec_event_path
  import pec_pkg::*;
#(
  parameter int NUM_SRC = 4,
  parameter int INC_W   = 8
) (
  input  logic                       clk,
  input  logic                       rst_n,
  input  logic [NUM_SRC*INC_W-1:0]   src_inc,
  input  logic [NUM_SRC*MASK_W-1:0]  src_sub,
  input  logic [SEL_W-1:0]           sel,
  input  logic [MASK_W-1:0]          mask,
  input  logic                       edge_md,
  output logic [INC_W-1:0]           cand,
  output logic                       evt_rise
);
  logic [INC_W-1:0]  inc_a [NUM_SRC];
  logic [MASK_W-1:0] sub_a [NUM_SRC];
  logic [INC_W-1:0]  inc_s;
  logic [MASK_W-1:0] sub_s;
  logic              hit, evt_on, evt_on_q;

  for (genvar g = 0; g < NUM_SRC; g++) begin : g_unpack
    assign inc_a[g] = src_inc[g*INC_W +: INC_W];
    assign sub_a[g] = src_sub[g*MASK_W +: MASK_W];
  end

  function automatic logic qualified(input logic [MASK_W-1:0] s,
                                     input logic [MASK_W-1:0] m);
    return (m == '0) || ((s & m) != '0);
  endfunction

  always_comb begin
    inc_s = '0;
    sub_s = '0;
    hit   = 1'b0;
    for (int i = 0; i < NUM_SRC; i++) begin
      if (sel == SEL_W'(i)) begin
        inc_s = inc_a[i];
        sub_s = sub_a[i];
        hit   = 1'b1;
      end
    end
  end

  assign evt_on   = hit && (inc_s != '0) && qualified(sub_s, mask);
  assign evt_rise = evt_on && !evt_on_q;

  always_ff @(posedge clk) begin
    if (!rst_n) evt_on_q <= 1'b0;
    else        evt_on_q <= evt_on;
  end

  always_comb begin
    if (edge_md) cand = evt_rise ? inc_s : '0;
    else         cand = evt_on   ? inc_s : '0;
  end
endmodule

// File: rtl/pec_accum.sv
module pec_accum
  import pec_pkg::*;
#(
  parameter int INC_W = 8,
  parameter int CNT_W = 48
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [INC_W-1:0] cand,
  input  logic [THR_W-1:0] thr,
  input  logic             inv,
  input  logic             max_md,
  input  logic             frz_en,
  input  logic             freeze_in,
  input  logic             clr,
  output logic [INC_W-1:0] step,
  output logic             ovf_evt,
  output logic [CNT_W-1:0] cnt,
  output logic             ovf_sticky,
  output logic             freeze_req
);
  localparam int CMP_W = (INC_W > THR_W) ? INC_W : THR_W;

  function automatic logic [INC_W-1:0] filter_step(input logic [INC_W-1:0] v,
                                                   input logic [THR_W-1:0] t,
                                                   input logic             invert);
    logic ge;
    ge = CMP_W'(v) >= CMP_W'(t);
    if (t == '0) return v;
    return (ge ^ invert) ? INC_W'(1) : '0;
  endfunction

  function automatic logic beats(input logic [INC_W-1:0] v,
                                 input logic [CNT_W-1:0] c);
    return CNT_W'(v) > c;
  endfunction

  logic [CNT_W:0] sum;
  logic           advance;

  assign step    = max_md ? '0 : filter_step(cand, thr, inv);
  assign sum     = {1'b0, cnt} + (CNT_W+1)'(step);
  assign advance = !clr && !freeze_in;
  assign ovf_evt = advance && !max_md && sum[CNT_W];

  always_ff @(posedge clk) begin
    if (!rst_n || clr) begin
      cnt        <= '0;
      ovf_sticky <= 1'b0;
    end else if (advance) begin
      if (max_md) begin
        if (beats(cand, cnt)) cnt <= CNT_W'(cand);
      end else begin
        cnt <= sum[CNT_W-1:0];
      end
      if (ovf_evt) ovf_sticky <= 1'b1;
    end
  end

  assign freeze_req = ovf_sticky && frz_en;
endmodule

// File: rtl/perf_event_counter.sv
module perf_event_counter
  import pec_pkg::*;
#(
  parameter int NUM_SRC = 4,
  parameter int INC_W   = 8,
  parameter int CNT_W   = 48
) (
  input  logic                      clk,
  input  logic                      rst_n,
  input  logic                      cfg_we,
  input  logic                      cfg_addr,
  input  logic [31:0]               cfg_wdata,
  output logic [31:0]               cfg_rdata,
  input  logic [NUM_SRC*INC_W-1:0]  src_inc,
  input  logic [NUM_SRC*MASK_W-1:0] src_sub,
  input  logic                      freeze_in,
  output logic [CNT_W-1:0]          cnt_value,
  output logic                      ovf_flag,
  output logic                      freeze_req
);
  pec_cfg_t         cfg;
  logic             clr_req;
  logic [INC_W-1:0] evt_cand;
  logic             evt_rise;
  logic [INC_W-1:0] acc_step;
  logic             acc_ovf_evt;

  pec_cfg_regs u_cfg (
    .clk(clk), .rst_n(rst_n), .we(cfg_we), .addr(cfg_addr),
    .wdata(cfg_wdata), .cfg(cfg), .clr_req(clr_req)
  );

  pec_event_path #(.NUM_SRC(NUM_SRC), .INC_W(INC_W)) u_evt (
    .clk(clk), .rst_n(rst_n), .src_inc(src_inc), .src_sub(src_sub),
    .sel(cfg.sel), .mask(cfg.mask), .edge_md(cfg.edge_md),
    .cand(evt_cand), .evt_rise(evt_rise)
  );

  pec_accum #(.INC_W(INC_W), .CNT_W(CNT_W)) u_acc (
    .clk(clk), .rst_n(rst_n), .cand(evt_cand), .thr(cfg.thr), .inv(cfg.inv),
    .max_md(cfg.max_md), .frz_en(cfg.frz_en), .freeze_in(freeze_in),
    .clr(clr_req), .step(acc_step), .ovf_evt(acc_ovf_evt),
    .cnt(cnt_value), .ovf_sticky(ovf_flag), .freeze_req(freeze_req)
  );

  assign cfg_rdata = cfg_addr ? pack_hi(cfg) : pack_lo(cfg);
endmodule

// File: rtl/pec_checker.sv
module pec_checker #(
  parameter int INC_W = 8,
  parameter int CNT_W = 48
) (
  input logic             clk,
  input logic             rst_n,
  input logic             clr,
  input logic             cfg_addr,
  input logic [31:0]      cfg_rdata,
  input logic             freeze_in,
  input logic [CNT_W-1:0] cnt_value,
  input logic             ovf_flag,
  input logic             freeze_req,
  input logic             max_md,
  input logic [7:0]       thr,
  input logic             edge_md,
  input logic             evt_rise,
  input logic [INC_W-1:0] cand,
  input logic [INC_W-1:0] step
);
  localparam logic [31:0] RSV_LO = 32'h0069_0000;
  localparam logic [31:0] RSV_HI = 32'hFFFF_FFFE;

  a_r3_clear_zeroes: assert property (@(posedge clk) disable iff (!rst_n)
    clr |=> (cnt_value == '0) && !ovf_flag);

  a_r11_freeze_holds: assert property (@(posedge clk) disable iff (!rst_n)
    freeze_in && !clr |=> $stable(cnt_value));

  a_r9_ovf_sticky: assert property (@(posedge clk) disable iff (!rst_n)
    ovf_flag && !clr |=> ovf_flag);

  a_r10_req_needs_ovf: assert property (@(posedge clk) disable iff (!rst_n)
    freeze_req |-> ovf_flag);

  a_r8_max_never_drops: assert property (@(posedge clk) disable iff (!rst_n)
    max_md && !clr |=> cnt_value >= $past(cnt_value));

  a_r6_thr_unit_step: assert property (@(posedge clk) disable iff (!rst_n)
    (thr != 8'd0) && !max_md |-> step <= INC_W'(1));

  a_r5_edge_only_rise: assert property (@(posedge clk) disable iff (!rst_n)
    edge_md && !evt_rise |-> cand == '0);

  a_r12_reserved_zero: assert property (@(posedge clk) disable iff (!rst_n)
    (cfg_rdata & (cfg_addr ? RSV_HI : RSV_LO)) == 32'h0);
endmodule

bind perf_event_counter pec_checker #(.INC_W(INC_W), .CNT_W(CNT_W)) u_chk (
  .clk(clk), .rst_n(rst_n), .clr(clr_req), .cfg_addr(cfg_addr),
  .cfg_rdata(cfg_rdata), .freeze_in(freeze_in), .cnt_value(cnt_value),
  .ovf_flag(ovf_flag), .freeze_req(freeze_req), .max_md(cfg.max_md),
  .thr(cfg.thr), .edge_md(cfg.edge_md), .evt_rise(evt_rise),
  .cand(evt_cand), .step(acc_step)
);

// File: tb/perf_event_counter_test.sv
module perf_event_counter_test;
  localparam int CLK_NS  = 10;
  localparam int NSRC    = 4;
  localparam int IW      = 8;
  localparam int CW      = 10;

  logic              clk = 1'b0;
  logic              rst_n = 1'b0;
  logic              cfg_we = 1'b0;
  logic              cfg_addr = 1'b0;
  logic [31:0]       cfg_wdata = '0;
  logic [31:0]       cfg_rdata;
  logic [NSRC*IW-1:0] src_inc = '0;
  logic [NSRC*8-1:0]  src_sub = '0;
  logic              freeze_in = 1'b0;
  logic [CW-1:0]     cnt_value;
  logic              ovf_flag, freeze_req;

  int n_chk = 0;
  int n_bad = 0;
  bit done  = 1'b0;

  always #(CLK_NS/2) clk = ~clk;

  perf_event_counter #(.NUM_SRC(NSRC), .INC_W(IW), .CNT_W(CW)) uut (
    .clk(clk), .rst_n(rst_n), .cfg_we(cfg_we), .cfg_addr(cfg_addr),
    .cfg_wdata(cfg_wdata), .cfg_rdata(cfg_rdata), .src_inc(src_inc),
    .src_sub(src_sub), .freeze_in(freeze_in), .cnt_value(cnt_value),
    .ovf_flag(ovf_flag), .freeze_req(freeze_req)
  );

  typedef struct packed {
    logic [31:0] tag;
    logic [31:0] lo;
    logic [31:0] hi;
    logic [31:0] inc;   // cycle k in bits 8k+7:8k
    logic [31:0] sub;
    logic [15:0] exp;
  } vec_t;

  localparam vec_t VT [9] = '{
    '{"R4", 32'h0000_0001, 32'h0, 32'h0205_0003, 32'h0000_0000, 16'd10},
    '{"R2", 32'h0000_0402, 32'h0, 32'h0404_0404, 32'h000C_0104, 16'd8},
    '{"R1", 32'h0000_0007, 32'h0, 32'h0909_0909, 32'h0000_0000, 16'd0},
    '{"R5", 32'h0004_0000, 32'h0, 32'h0600_0302, 32'h0000_0000, 16'd8},
    '{"R6", 32'h0500_0003, 32'h0, 32'h0009_0405, 32'h0000_0000, 16'd2},
    '{"R7", 32'h0580_0003, 32'h0, 32'h0009_0405, 32'h0000_0000, 16'd2},
    '{"R8", 32'hFF00_0001, 32'h1, 32'h0702_0703, 32'h0000_0000, 16'd7},
    '{"R5", 32'h0004_0200, 32'h0, 32'h0505_0505, 32'h0200_0202, 16'd10},
    '{"R6", 32'h0300_0002, 32'h0, 32'hFF02_C803, 32'h0000_0000, 16'd3}
  };

  task automatic tick();
    @(posedge clk);
    @(negedge clk);
  endtask

  task automatic chk(input string tag, input logic [63:0] act, input logic [63:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s: actual %0h expected %0h", tag, act, exp);
    end
  endtask

  task automatic wr(input logic a, input logic [31:0] d);
    cfg_we = 1'b1; cfg_addr = a; cfg_wdata = d;
    tick();
    cfg_we = 1'b0; cfg_wdata = '0;
  endtask

  // Stimulus on the selected source; the other sources carry busy traffic.
  task automatic stim(input logic [7:0] sel, input logic [7:0] inc, input logic [7:0] sub);
    for (int i = 0; i < NSRC; i++) begin
      if (sel >= NSRC || sel == 8'(i)) begin
        src_inc[i*IW +: IW] = inc;
        src_sub[i*8 +: 8]   = sub;
      end else begin
        src_inc[i*IW +: IW] = 8'h77;
        src_sub[i*8 +: 8]   = 8'hFF;
      end
    end
  endtask

  task automatic idle();
    src_inc = '0; src_sub = '0;
  endtask

  initial begin
    #(CLK_NS * 50000);
    if (!done) begin
      n_bad++;
      $display("FAIL watchdog: actual running expected finished");
      $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
      $finish;
    end
  end

  initial begin
    tick(); tick();
    rst_n = 1'b1;
    tick();
    // R12 reset state
    chk("R12 cnt", 64'(cnt_value), 0);
    chk("R12 ovf", 64'(ovf_flag), 0);
    chk("R12 freeze_req", 64'(freeze_req), 0);
    cfg_addr = 1'b0; #1; chk("R12 lo", 64'(cfg_rdata), 0);
    cfg_addr = 1'b1; #1; chk("R12 hi", 64'(cfg_rdata), 0);

    // vector table walk
    foreach (VT[v]) begin
      wr(1'b1, VT[v].hi);
      wr(1'b0, VT[v].lo | 32'h0002_0000);
      for (int k = 0; k < 4; k++) begin
        stim(VT[v].lo[7:0], VT[v].inc[8*k +: 8], VT[v].sub[8*k +: 8]);
        tick();
      end
      idle();
      chk($sformatf("%s vector %0d", VT[v].tag, v), 64'(cnt_value), 64'(VT[v].exp));
    end
    wr(1'b1, 32'h0);

    // R12 / R3 readback with reserved bits and the clear strobe
    wr(1'b0, 32'hFFFF_FFFF);
    cfg_addr = 1'b0; #1; chk("R3 R12 lo readback", 64'(cfg_rdata), 64'hFF94_FFFF);
    wr(1'b1, 32'hFFFF_FFFF);
    cfg_addr = 1'b1; #1; chk("R12 hi readback", 64'(cfg_rdata), 1);
    wr(1'b1, 32'h0);

    // R9 / R10 overflow with a 10-bit counter, freeze enabled
    wr(1'b0, 32'h0012_0000);
    for (int k = 0; k < 4; k++) begin stim(0, 8'd255, 0); tick(); end
    chk("R9 below wrap cnt", 64'(cnt_value), 1020);
    chk("R9 below wrap ovf", 64'(ovf_flag), 0);
    stim(0, 8'd10, 0); tick(); idle();
    chk("R9 wrap residue", 64'(cnt_value), 6);
    chk("R9 wrap flag", 64'(ovf_flag), 1);
    chk("R10 freeze_req", 64'(freeze_req), 1);
    tick(); tick();
    chk("R9 flag sticky", 64'(ovf_flag), 1);
    wr(1'b0, 32'h0000_0000);
    chk("R10 req off with bit 20 clear", 64'(freeze_req), 0);
    chk("R9 flag kept without clear", 64'(ovf_flag), 1);
    wr(1'b0, 32'h0002_0000);
    chk("R3 clear flag", 64'(ovf_flag), 0);
    chk("R3 clear cnt", 64'(cnt_value), 0);

    // R11 freeze, R3 clear under freeze and over counting
    stim(0, 8'd4, 0); tick(); tick();
    chk("R4 pre-freeze", 64'(cnt_value), 8);
    freeze_in = 1'b1; tick(); tick();
    chk("R11 held", 64'(cnt_value), 8);
    wr(1'b0, 32'h0002_0000);
    chk("R3 clear while frozen", 64'(cnt_value), 0);
    freeze_in = 1'b0; tick();
    chk("R11 resumes", 64'(cnt_value), 4);
    wr(1'b0, 32'h0002_0000);
    chk("R3 clear beats count", 64'(cnt_value), 0);
    idle(); tick();

    done = 1'b1;
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end
endmodule